// File: doc/BRIEF.md
# Three-wire nibble register access master

This block is a bit-serial master for a peripheral that keeps its state in 4-bit registers. The peripheral is reached over three wires: a chip enable, a serial clock that idles high, and one bidirectional data line. The block provides the data line as three separate signals: data out, output enable and data in. The pad buffer is outside the block.

A host starts a transaction with a one-cycle start pulse. The pulse carries a direction flag, a 4-bit register address and, for writes, a 4-bit value. The block then shifts out a tagged command byte, most significant bit first.

- A write continues with a tagged data byte.
- A read continues with eight clocks during which the data line is released. The block then returns the last four bits it sampled.

The host runs the chip enable itself. It drives a dedicated input that the block passes straight through to the line.

Bit timing comes from a parameterized divider of the system clock. `HALF_CYCLES` system cycles form one half period. The default of 36 cycles at 50 MHz gives 720 ns, which satisfies the 700 ns minimum the peripheral needs.

Top module: `nibble_ser_master`

## Requirements
- R1: After reset: ser_sclk is 1, ser_oe is 0, busy is 0 and done is 0.
- R2: ser_sclk is high whenever the block is idle. A transaction consists of 16 bit cells. Each cell is HALF_CYCLES system cycles with ser_sclk high, then HALF_CYCLES cycles with ser_sclk low. Every low phase therefore lasts exactly HALF_CYCLES cycles.
- R3: Bytes are sent most significant bit first. The bit of a cell is on ser_sdo from the start of the cell's high phase and holds until the cell ends, so it is valid before ser_sclk falls.
- R4: A read sends the command byte {4'b0110, addr}, in which bit 6 is the read tag and bit 5 is the address tag. It is followed by eight cells with ser_oe at 0.
- R5: On a read, ser_sdi is sampled at the end of each cell's high phase. When done is high, rdata holds the last four sampled bits, the first of these in bit 3.
- R6: A write sends {4'b0010, addr} followed by {4'b0001, wdata}, in which bit 4 is the data tag. The upper nibble of the second byte is never taken from wdata.
- R7: ser_oe is 1 exactly during transmitted cells. It rises with the first bit and falls when the last transmitted cell ends. A read's receive cells have ser_oe at 0.
- R8: busy goes high in the cycle after an accepted start and stays high for 32*HALF_CYCLES cycles. done is high for exactly one cycle, the first cycle after busy falls.
- R9: A start pulse while busy is 1 is ignored. The running transaction's bytes are unchanged, only one done pulse occurs, and no new transaction follows.
- R10: ser_ce always equals ce_req, with no dependence on the transaction state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a transaction |
| rw | input | 1 | 1 selects read, 0 selects write |
| addr | input | 4 | Register address |
| wdata | input | 4 | Value to write |
| ce_req | input | 1 | Host chip-enable level |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 4 | Nibble returned by the last read |
| ser_ce | output | 1 | Chip-enable line |
| ser_sclk | output | 1 | Serial clock, idles high |
| ser_sdo | output | 1 | Serial data toward the peripheral |
| ser_oe | output | 1 | Output enable for the data line |
| ser_sdi | input | 1 | Serial data from the peripheral |

## Verification
The bench acts as the peripheral. It captures ser_sdo and ser_oe at every falling clock edge and feeds read bits on every rising edge, so a swapped sample point or a bit-order reversal shows up as a wrong nibble.

Read bytes whose halves differ, such as 0xF0 and 0xA5, expose a design that returns the upper nibble or fails to mask. Per-cell enable capture catches an enable that stays on through the receive cells or drops between the two bytes of a write.

A start injected mid-transaction with inverted fields catches a design that relatches its inputs or restarts. Exact counts of low-phase length and busy length catch an off-by-one in the divider.

// File: rtl/nibble_ser_pkg.sv
package nibble_ser_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    localparam logic [NIB_W-1:0] TAG_RD_CMD = 4'b0110;
    localparam logic [NIB_W-1:0] TAG_WR_CMD = 4'b0010;
    localparam logic [NIB_W-1:0] TAG_WR_DAT = 4'b0001;

    typedef struct packed {
        logic              busy;
        logic              rd;
        logic              phase;    // 0: high half, 1: low half
        logic              slot;     // 0: command byte, 1: second byte
        logic [BIT_W-1:0]  bit_idx;
        logic              sclk;
        logic              oe;
        logic              done;
        logic              smp;
        logic [NIB_W-1:0]  rdata;
        logic [BYTE_W-1:0] second;
    } seq_state_t;
endpackage

// File: rtl/nsm_half_timer.sv
module nsm_half_timer #(
    parameter int HALF_CYCLES = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nsm_byte_shifter.sv
module nsm_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic         msb,
    output logic [W-1:0] shifted
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        shifted = {sr_q[W-2:0], shift_in};
        if (load)       sr_d = load_val;
        else if (shift) sr_d = shifted;
        else            sr_d = sr_q;
        msb = sr_q[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end
endmodule

// File: rtl/nsm_seq.sv
module nsm_seq
    import nibble_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rw,
    input  logic [NIB_W-1:0]  addr,
    input  logic [NIB_W-1:0]  wdata,
    input  logic              tick,
    input  logic              sdi,
    input  logic              sdo_in,
    input  logic [BYTE_W-1:0] shifted,
    output logic              load,
    output logic [BYTE_W-1:0] load_val,
    output logic              shift,
    output logic              shift_in,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              oe,
    output logic [NIB_W-1:0]  rdata
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    seq_state_t d, q;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        load     = 1'b0;
        shift    = 1'b0;
        load_val = '0;
        if (!q.busy) begin
            d.sclk = 1'b1;
            d.oe   = 1'b0;
            if (start) begin
                d.busy    = 1'b1;
                d.rd      = rw;
                d.phase   = 1'b0;
                d.slot    = 1'b0;
                d.bit_idx = '0;
                d.oe      = 1'b1;
                d.second  = rw ? '0 : {TAG_WR_DAT, wdata};
                load      = 1'b1;
                load_val  = {(rw ? TAG_RD_CMD : TAG_WR_CMD), addr};
            end
        end else if (tick) begin
            if (!q.phase) begin
                d.phase = 1'b1;
                d.sclk  = 1'b0;
                d.smp   = sdi;
            end else begin
                d.phase = 1'b0;
                d.sclk  = 1'b1;
                if (q.bit_idx == LAST_BIT) begin
                    d.bit_idx = '0;
                    if (!q.slot) begin
                        d.slot   = 1'b1;
                        d.oe     = !q.rd;
                        load     = 1'b1;
                        load_val = q.second;
                    end else begin
                        d.busy = 1'b0;
                        d.oe   = 1'b0;
                        d.done = 1'b1;
                        d.slot = 1'b0;
                        if (q.rd) d.rdata = shifted[NIB_W-1:0];
                    end
                end else begin
                    d.bit_idx = q.bit_idx + 1'b1;
                    shift     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign shift_in = q.smp;
    assign run      = q.busy;
    assign busy     = q.busy;
    assign done     = q.done;
    assign sclk     = q.sclk;
    assign oe       = q.oe;
    assign rdata    = q.rdata;

    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);                                         // R2
    AST_TICK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> busy);                                          // R2
    AST_SDO_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && $past(!sclk)) |-> $stable(sdo_in));            // R3
    AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> busy);                                            // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                         // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                        // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q.second));                  // R9
endmodule

// File: rtl/nibble_ser_master.sv
module nibble_ser_master
    import nibble_ser_pkg::*;
#(
    parameter int HALF_CYCLES = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rw,
    input  logic [NIB_W-1:0] addr,
    input  logic [NIB_W-1:0] wdata,
    input  logic             ce_req,
    output logic             busy,
    output logic             done,
    output logic [NIB_W-1:0] rdata,
    output logic             ser_ce,
    output logic             ser_sclk,
    output logic             ser_sdo,
    output logic             ser_oe,
    input  logic             ser_sdi
);
    logic              tick, run, load, shift, shift_in, msb;
    logic [BYTE_W-1:0] load_val, shifted;

    nsm_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    nsm_byte_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .shift(shift), .shift_in(shift_in), .msb(msb), .shifted(shifted)
    );

    nsm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .addr(addr),
        .wdata(wdata), .tick(tick), .sdi(ser_sdi), .sdo_in(msb),
        .shifted(shifted), .load(load), .load_val(load_val), .shift(shift),
        .shift_in(shift_in), .run(run), .busy(busy), .done(done),
        .sclk(ser_sclk), .oe(ser_oe), .rdata(rdata)
    );

    assign ser_sdo = msb;
    assign ser_ce  = ce_req;
endmodule

// File: tb/nibble_ser_master_test.sv
`timescale 1ns/1ps
module nibble_ser_master_test;
    localparam int HALF = 36;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, rw = 1'b0, ce_req = 1'b0, ser_sdi = 1'b0;
    logic [3:0] addr = '0, wdata = '0;
    logic busy, done, ser_ce, ser_sclk, ser_sdo, ser_oe;
    logic [3:0] rdata;

    always #10 clk = ~clk;

    nibble_ser_master #(.HALF_CYCLES(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .addr(addr),
        .wdata(wdata), .ce_req(ce_req), .busy(busy), .done(done),
        .rdata(rdata), .ser_ce(ser_ce), .ser_sclk(ser_sclk),
        .ser_sdo(ser_sdo), .ser_oe(ser_oe), .ser_sdi(ser_sdi)
    );

    int checks = 0, errors = 0, cyc = 0;
    int k = 0, busycnt = 0, donecnt = 0, lowrun = 0, minlow = 0, maxlow = 0;
    logic [7:0]  sbyte = '0;
    logic [15:0] sent = '0, oebits = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // peripheral model
    always @(negedge ser_sclk) if (k < 16) begin
        sent[15-k]   = ser_sdo;
        oebits[15-k] = ser_oe;
    end
    always @(posedge ser_sclk) begin
        k = k + 1;
        if (k >= 8 && k < 16) ser_sdi = sbyte[15-k];
    end

    always @(negedge clk) begin
        if (busy) busycnt++;
        if (done) donecnt++;
        if (!ser_sclk) lowrun++;
        else if (lowrun > 0) begin
            if (lowrun < minlow) minlow = lowrun;
            if (lowrun > maxlow) maxlow = lowrun;
            lowrun = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [7:0] exp_cmd(input bit r, input logic [3:0] a);
        return {(r ? 4'b0110 : 4'b0010), a};
    endfunction

    task automatic run_txn(input bit r, input logic [3:0] a, input logic [3:0] w,
                           input logic [7:0] rb, input bit poke);
        int t;
        logic [3:0] prev;
        prev = rdata;
        k = 0; sbyte = rb; ser_sdi = 1'b0;
        busycnt = 0; donecnt = 0; lowrun = 0; minlow = 1000000; maxlow = 0;
        @(negedge clk); start = 1'b1; rw = r; addr = a; wdata = w;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (poke) begin
            repeat (200) @(negedge clk);
            start = 1'b1; rw = ~r; addr = ~a; wdata = ~w;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (!done && t < 40*HALF) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R8", "done seen", done, 1);
        chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
        if (r) chk(rdata == rb[3:0], "R5", "read nibble", rdata, rb[3:0]);
        else   chk(rdata == prev, "R6", "rdata kept on write", rdata, prev);
        chk(sent[15:8] == exp_cmd(r, a), r ? "R4" : "R6", "command byte",
            sent[15:8], exp_cmd(r, a));
        if (!r) chk(sent[7:0] == {4'b0001, w}, "R6", "data byte", sent[7:0], {4'b0001, w});
        chk(oebits == (r ? 16'hFF00 : 16'hFFFF), "R7", "oe per cell",
            oebits, r ? 16'hFF00 : 16'hFFFF);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", done, 0);
        chk(donecnt == 1, poke ? "R9" : "R8", "done count", donecnt, 1);
        chk(busycnt == 32*HALF, "R8", "busy length", busycnt, 32*HALF);
        chk(k == 16, "R2", "cell count", k, 16);
        chk(minlow == HALF && maxlow == HALF, "R2", "low phase length", minlow, HALF);
        chk(ser_sclk == 1'b1 && ser_oe == 1'b0, "R2", "idle lines",
            {ser_sclk, ser_oe}, 2'b10);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b0 && k == 16, "R9", "no restart after ignored start", busy, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(ser_sclk == 1'b1, "R1", "reset sclk", ser_sclk, 1);
        chk(ser_oe == 1'b0, "R1", "reset oe", ser_oe, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ce_req = 1'b1; #1;
        chk(ser_ce == 1'b1, "R10", "ce high", ser_ce, 1);
        ce_req = 1'b0; #1;
        chk(ser_ce == 1'b0, "R10", "ce low", ser_ce, 0);
        ce_req = 1'b1;

        run_txn(1'b1, 4'hF, 4'h0, 8'hA5, 1'b0);   // R3 R5 alternating bits
        run_txn(1'b1, 4'h0, 4'h0, 8'hF0, 1'b0);   // R5 upper nibble masked
        run_txn(1'b1, 4'h9, 4'h0, 8'h0F, 1'b0);
        run_txn(1'b0, 4'h0, 4'hF, 8'h00, 1'b0);   // R6
        run_txn(1'b0, 4'hE, 4'h0, 8'h00, 1'b0);
        run_txn(1'b1, 4'h3, 4'h0, 8'h3C, 1'b1);   // R9 read
        run_txn(1'b0, 4'h5, 4'hA, 8'h00, 1'b1);   // R9 write
        for (int i = 0; i < 28; i++) begin
            run_txn(1'($urandom % 2), 4'($urandom), 4'($urandom), 8'($urandom), 1'b0);
            if (i % 7 == 0) begin
                ce_req = ~ce_req; #1;
                chk(ser_ce == ce_req, "R10", "ce follows", ser_ce, ce_req);
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule